// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Slice

This block is a programmable AND-OR logic slice. A configuration port writes rows of an AND array; each row forms one product term over a set of literals. The literals are the dedicated inputs, the clock level and one feedback signal per output cell. Every output cell ORs a fixed group of product terms. It can then invert the sum and either pass it straight through or capture it in a flip-flop on the rising clock edge. A separate product term per cell can drive the cell's output enable, or the cell can use a shared enable pin instead.

The slice is used by loading a function through the configuration port while the load enable is held high. During that time every output enable is forced low and no cell register changes. Once the load enable is released, the slice computes the loaded function. Pads are modelled with a separate output value, output enable and pad input per cell. Combinational cells feed their pad input back into the array. Registered cells feed their register output back.

Top module: `sop_logic_slice`

## Requirements
- R1: A product-term row with both the keep-true bit (row bit 2j) and the keep-complement bit (row bit 2j+1) set for an array literal j evaluates to 0. A cell whose rows all stay in this reset pattern outputs 0 before inversion.
- R2: A literal whose two row bits are both clear leaves the product unaffected, so a row of all zeros evaluates to 1.
- R3: A cell's sum is the OR of its N_SUM product terms, held in configuration slots 0 to N_SUM-1.
- R4: Mode bit 1 (invert) complements the sum before it reaches the register or the pin.
- R5: With mode bit 0 (registered) set, the pin output shows a value captured at the rising clock edge and holds it between edges.
- R6: With mode bit 0 clear, the pin output follows the array inputs in the same cycle, and the cell register does not change.
- R7: Mode bit 2 selects the output enable source: clear means the shared enable pin, set means the product term in slot N_SUM.
- R8: Array literal order is: index 0 the clock level, indices 1..N_DED the dedicated inputs, then one feedback per cell. A cell's feedback is its register output when registered, and its pad input when combinational.
- R9: The clock literal carries the clock level only while no cell is registered. Otherwise it reads as 0.
- R10: While cfg_load is high, all pin output enables are 0 and no cell register changes. A configuration write (cfg_we) takes effect only while cfg_load is high.
- R11: Reset sets every row to the both-bits-set pattern, clears all mode bits and clears every cell register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the array literal 0 |
| rst | input | 1 | Synchronous active-high reset |
| din | input | N_DED | Dedicated array inputs |
| oe_pin | input | 1 | Shared output enable pin |
| pin_in | input | N_CELL | Pad input value per cell |
| pin_out | output | N_CELL | Pad output value per cell |
| pin_oe | output | N_CELL | Pad output enable per cell |
| cfg_load | input | 1 | Configuration load enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cell | input | $clog2(N_CELL) | Target cell of a write |
| cfg_slot | input | $clog2(N_SUM+2) | Slot: 0..N_SUM-1 sum rows, N_SUM enable row, N_SUM+1 mode bits |
| cfg_data | input | 2*(1+N_DED+N_CELL) | Row bits, or mode bits in [2:0] |

## Verification
The bench builds the slice with its default parameters: ten dedicated inputs, ten cells and eight sum terms per cell. This gives a 42-bit row. With these values a 4-bit counter with clear and count enable fits in four registered cells. The widest bit needs five product terms. Alongside it run a 2-to-4 decoder, an inverted empty cell, an enable driven by a product term and a cell that reads another cell's pad. Together they exercise register and pad feedback, the clock literal in both of its states, and the freeze during loading.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef struct packed {
        logic oe_from_term;
        logic invert;
        logic registered;
    } cell_mode_t;

    typedef enum logic [1:0] {
        SLOT_SUM,
        SLOT_OE,
        SLOT_MODE,
        SLOT_NONE
    } slot_kind_e;

    function automatic slot_kind_e slot_kind(input int slot, input int n_sum);
        if (slot < n_sum)
            return SLOT_SUM;
        else if (slot == n_sum)
            return SLOT_OE;
        else if (slot == n_sum + 1)
            return SLOT_MODE;
        return SLOT_NONE;
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
    import sop_pkg::*;
#(
    parameter int N_CELL = 10,
    parameter int N_SUM  = 8,
    parameter int ROW_W  = 42,
    localparam int CELL_W = $clog2(N_CELL),
    localparam int SLOT_W = $clog2(N_SUM + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              cfg_we,
    input  logic [CELL_W-1:0] cfg_cell,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ROW_W-1:0]  cfg_data,
    output logic [ROW_W-1:0]  sum_rows [N_CELL][N_SUM],
    output logic [ROW_W-1:0]  oe_rows  [N_CELL],
    output cell_mode_t        modes    [N_CELL]
);

    slot_kind_e kind;
    assign kind = slot_kind(int'(cfg_slot), N_SUM);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CELL; c++) begin
                for (int s = 0; s < N_SUM; s++)
                    sum_rows[c][s] <= '1;
                oe_rows[c] <= '1;
                modes[c]   <= '0;
            end
        end else if (cfg_load && cfg_we) begin
            for (int c = 0; c < N_CELL; c++) begin
                if (int'(cfg_cell) == c) begin
                    case (kind)
                        SLOT_SUM: begin
                            for (int s = 0; s < N_SUM; s++)
                                if (int'(cfg_slot) == s)
                                    sum_rows[c][s] <= cfg_data;
                        end
                        SLOT_OE:   oe_rows[c] <= cfg_data;
                        SLOT_MODE: modes[c]   <= cell_mode_t'(cfg_data[2:0]);
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/sop_product_term.sv
module sop_product_term #(
    parameter int N_ARR = 21,
    localparam int ROW_W = 2 * N_ARR
) (
    input  logic [ROW_W-1:0] row,
    input  logic [N_ARR-1:0] lits,
    output logic             term
);

    always_comb begin
        term = 1'b1;
        for (int j = 0; j < N_ARR; j++) begin
            if (row[2*j] && !lits[j])
                term = 1'b0;
            if (row[2*j+1] && lits[j])
                term = 1'b0;
        end
    end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int N_SUM = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [N_SUM-1:0] sum_terms,
    input  logic             oe_term,
    input  cell_mode_t       mode,
    input  logic             oe_pin,
    input  logic             pad_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb
);

    logic d;
    logic q;

    assign d = (|sum_terms) ^ mode.invert;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (mode.registered && !cfg_load)
            q <= d;
    end

    assign pin_out = mode.registered ? q : d;
    assign fb      = mode.registered ? q : pad_in;
    assign pin_oe  = cfg_load ? 1'b0 : (mode.oe_from_term ? oe_term : oe_pin);

    assert_hold_in_load_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> $stable(q));

    assert_reg_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (mode.registered && !cfg_load) |=> (q == $past(d)));

    assert_comb_reg_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !mode.registered |=> $stable(q));

endmodule

// File: rtl/sop_logic_slice.sv
module sop_logic_slice
    import sop_pkg::*;
#(
    parameter int N_DED  = 10,
    parameter int N_CELL = 10,
    parameter int N_SUM  = 8,
    localparam int N_ARR  = 1 + N_DED + N_CELL,
    localparam int ROW_W  = 2 * N_ARR,
    localparam int CELL_W = $clog2(N_CELL),
    localparam int SLOT_W = $clog2(N_SUM + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_DED-1:0]  din,
    input  logic              oe_pin,
    input  logic [N_CELL-1:0] pin_in,
    output logic [N_CELL-1:0] pin_out,
    output logic [N_CELL-1:0] pin_oe,
    input  logic              cfg_load,
    input  logic              cfg_we,
    input  logic [CELL_W-1:0] cfg_cell,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ROW_W-1:0]  cfg_data
);

    logic [ROW_W-1:0]  sum_rows [N_CELL][N_SUM];
    logic [ROW_W-1:0]  oe_rows  [N_CELL];
    cell_mode_t        modes    [N_CELL];
    logic [N_SUM-1:0]  sum_terms [N_CELL];
    logic [N_CELL-1:0] oe_terms;
    logic [N_CELL-1:0] fb;
    logic [N_CELL-1:0] reg_mask;
    logic              clk_lit;
    logic [N_ARR-1:0]  lits;

    sop_cfg_store #(
        .N_CELL (N_CELL),
        .N_SUM  (N_SUM),
        .ROW_W  (ROW_W)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_we   (cfg_we),
        .cfg_cell (cfg_cell),
        .cfg_slot (cfg_slot),
        .cfg_data (cfg_data),
        .sum_rows (sum_rows),
        .oe_rows  (oe_rows),
        .modes    (modes)
    );

    always_comb begin
        for (int c = 0; c < N_CELL; c++)
            reg_mask[c] = modes[c].registered;
    end

    assign clk_lit = clk & ~(|reg_mask);
    assign lits    = {fb, din, clk_lit};

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        for (genvar s = 0; s < N_SUM; s++) begin : g_sum
            sop_product_term #(.N_ARR(N_ARR)) u_term (
                .row  (sum_rows[c][s]),
                .lits (lits),
                .term (sum_terms[c][s])
            );
        end

        sop_product_term #(.N_ARR(N_ARR)) u_oe_term (
            .row  (oe_rows[c]),
            .lits (lits),
            .term (oe_terms[c])
        );

        sop_macrocell #(.N_SUM(N_SUM)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .cfg_load  (cfg_load),
            .sum_terms (sum_terms[c]),
            .oe_term   (oe_terms[c]),
            .mode      (modes[c]),
            .oe_pin    (oe_pin),
            .pad_in    (pin_in[c]),
            .pin_out   (pin_out[c]),
            .pin_oe    (pin_oe[c]),
            .fb        (fb[c])
        );

        assert_oe_from_pin_R7: assert property (@(posedge clk) disable iff (rst)
            (!cfg_load && !modes[c].oe_from_term) |-> (pin_oe[c] == oe_pin));
    end

    assert_load_oe_off_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> (pin_oe == '0));

endmodule

// File: tb/sop_logic_slice_bench.sv
module sop_logic_slice_bench;

    localparam int PERIOD = 10;
    localparam int N_DED  = 10;
    localparam int N_CELL = 10;
    localparam int N_SUM  = 8;
    localparam int N_ARR  = 1 + N_DED + N_CELL;
    localparam int ROW_W  = 2 * N_ARR;
    localparam int CELL_W = $clog2(N_CELL);
    localparam int SLOT_W = $clog2(N_SUM + 2);
    localparam int SLOT_OE   = N_SUM;
    localparam int SLOT_MODE = N_SUM + 1;
    localparam int L_CLK = 0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_DED-1:0]  din = '0;
    logic              oe_pin = 1'b1;
    logic [N_CELL-1:0] pin_in = '0;
    logic [N_CELL-1:0] pin_out;
    logic [N_CELL-1:0] pin_oe;
    logic              cfg_load = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CELL_W-1:0] cfg_cell = '0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [ROW_W-1:0]  cfg_data = '0;

    always #(PERIOD/2) clk = ~clk;

    sop_logic_slice #(.N_DED(N_DED), .N_CELL(N_CELL), .N_SUM(N_SUM)) u_sop_logic_slice (
        .clk(clk), .rst(rst), .din(din), .oe_pin(oe_pin), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .cfg_load(cfg_load), .cfg_we(cfg_we),
        .cfg_cell(cfg_cell), .cfg_slot(cfg_slot), .cfg_data(cfg_data)
    );

    typedef struct {
        logic [N_CELL-1:0] out;
        logic [N_CELL-1:0] mask;
        logic [N_CELL-1:0] oe;
        bit                use_cnt;
        string             tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    int    phase  = 0;
    bit    done   = 0;
    logic [3:0] cnt = '0;

    function automatic int l_din(int d); return 1 + d; endfunction
    function automatic int l_fb(int c);  return 1 + N_DED + c; endfunction
    function automatic logic [ROW_W-1:0] kt(int j);
        logic [ROW_W-1:0] r = '0; r[2*j] = 1'b1; return r;
    endfunction
    function automatic logic [ROW_W-1:0] kc(int j);
        logic [ROW_W-1:0] r = '0; r[2*j+1] = 1'b1; return r;
    endfunction

    // Reference counter model: clear on din[0], count on din[1] (R5, R8)
    always @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (phase == 2 && !cfg_load)
            cnt <= din[0] ? 4'd0 : (din[1] ? cnt + 4'd1 : cnt);
    end

    // Monitor: pops expected items and compares after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() != 0) begin
            item_t it;
            logic [N_CELL-1:0] exp_out;
            it = sb.pop_front();
            exp_out = it.out;
            if (it.use_cnt) exp_out[3:0] = cnt;
            checks++;
            if ((((pin_out ^ exp_out) & it.mask) != '0) || (pin_oe !== it.oe)) begin
                fails++;
                $display("FAIL %s: out=%h exp %h (mask %h) oe=%h exp %h",
                         it.tag, pin_out, exp_out, it.mask, pin_oe, it.oe);
            end
        end
    end

    task automatic step(input logic [N_DED-1:0] d, input logic oep,
                        input logic [N_CELL-1:0] pv, input string tag);
        item_t it;
        @(negedge clk);
        din = d; oe_pin = oep; pin_in = pv;
        it.out = '0; it.mask = '1; it.oe = {N_CELL{oep}}; it.use_cnt = 0; it.tag = tag;
        if (phase >= 1) begin
            it.out[0] = 1'b1;
            it.out[4] = 1'b1;
            it.out[5 + int'(d[3:2])] = 1'b1;
            it.out[9] = 1'b1;
            it.oe[9] = d[4];
        end
        if (phase == 2) begin
            it.use_cnt = 1;
            it.out[4] = pv[9];
        end
        if (cfg_load) begin
            it.oe = '0;
            it.mask = (phase == 2) ? N_CELL'(4'hF) : '0;
        end
        sb.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int c, input int s, input logic [ROW_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cell = CELL_W'(c); cfg_slot = SLOT_W'(s); cfg_data = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_on();  @(negedge clk); cfg_load = 1'b1; endtask
    task automatic load_off(); @(negedge clk); cfg_load = 1'b0; endtask

    task automatic program_counter_bit(input int k);
        logic [ROW_W-1:0] r;
        wr(k, 0, kt(l_fb(k)) | kc(l_din(1)) | kc(l_din(0)));
        for (int j = 0; j < k; j++)
            wr(k, 1 + j, kt(l_fb(k)) | kc(l_fb(j)) | kc(l_din(0)));
        r = kc(l_fb(k)) | kt(l_din(1)) | kc(l_din(0));
        for (int j = 0; j < k; j++) r |= kt(l_fb(j));
        wr(k, k + 1, r);
        wr(k, SLOT_MODE, ROW_W'(3'b001));
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: out=%h exp %h", pin_out, pin_out);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset state: all rows unprogrammed, comb, pin enable
        step('0, 1'b1, '0, "R1/R11 reset outputs low, enables from pin");
        step(10'h3FF, 1'b0, '1, "R1/R7 unprogrammed cells with enable pin low");

        // Combinational functions
        load_on();
        wr(0, SLOT_MODE, ROW_W'(3'b010));
        step('0, 1'b1, '0, "R10 enables off during load");
        wr(4, 0, kt(l_fb(9)));
        wr(4, 1, kt(L_CLK));
        for (int k = 0; k < 4; k++)
            wr(5 + k, 0, ((k & 1) ? kt(l_din(2)) : kc(l_din(2))) |
                         ((k & 2) ? kt(l_din(3)) : kc(l_din(3))));
        wr(9, 0, '0);
        wr(9, SLOT_OE, kt(l_din(4)));
        wr(9, SLOT_MODE, ROW_W'(3'b100));
        load_off();
        phase = 1;

        for (int v = 0; v < 4; v++)
            step(N_DED'(v << 2), 1'b1, '0, "R6 R4 R2 R9 decoder, inverted cell, clock literal");
        step(10'h010, 1'b1, '0, "R7 enable from product term high");
        step(10'h00C, 1'b0, '0, "R7 enable pin low, term-driven cell low");

        // Write without load must be ignored
        wr(9, SLOT_MODE, ROW_W'(3'b110));
        step(10'h010, 1'b1, '0, "R10 write without load ignored");

        // Counter in cells 0..3
        load_on();
        for (int k = 0; k < 4; k++) program_counter_bit(k);
        phase = 2;
        load_off();

        step(10'h000, 1'b1, '0, "R5 counter idle at zero");
        for (int i = 0; i < 18; i++)
            step(10'h002, 1'b1, (i % 3 == 0) ? N_CELL'(1) << 9 : '0,
                 "R3 R5 R8 R9 counting, pad feedback cell");
        step(10'h000, 1'b1, '0, "R5 count held with enable low");
        step(10'h000, 1'b1, '0, "R5 count still held");

        load_on();
        step(10'h002, 1'b1, '0, "R10 register frozen while loading");
        wr(4, 1, kt(L_CLK));
        step(10'h003, 1'b1, '0, "R10 register frozen, clear ignored while loading");
        load_off();

        step(10'h002, 1'b1, '0, "R5 counting resumes");
        step(10'h003, 1'b1, '0, "R5 synchronous clear");
        for (int i = 0; i < 3; i++)
            step(10'h002, 1'b1, '1, "R8 R9 counting after clear, pad high");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule